// File: doc/BRIEF.md
# Stack Call and Return Bus Sequencer

This block drives the bus, one access per clock, for the stack-using instructions of an 8-bit processor: register push, register pull, subroutine call, subroutine return and return from interrupt. The opcode fetch has already happened elsewhere. A controller pulses `start` with a class code and the current program counter, stack pointer, accumulator and status byte. From the next clock the block issues every read and write of the instruction, starting at the instruction's second cycle. This includes the throw-away operand read and the stack read that only bumps the pointer.

The stack always sits in one fixed page, which is page 1 by default, and the pointer wraps modulo 256 inside that page. When the last bus cycle ends, the block raises `done` for one clock. At that point `pc_out` and `sp_out` hold the updated pointers and `pull_val` holds the byte that was pulled. For a pulled status byte, bits 5 and 4 come from the status value given at start and not from memory. `pc_in` is the address of the byte that follows the opcode.

Top module: `stack_call_seq`

## Requirements
- R1: Each accepted operation starts its first bus cycle one clock after `start`, as a read at `pc_in`. Only the call class advances the PC in that cycle.
- R2: Push (class 0 pushes `a_in`, class 1 pushes `p_in`) takes two bus cycles. The second is a write of the register to 0x0100+S. S ends at S-1.
- R3: Pull (class 2 to A, class 3 to P) takes three bus cycles. After the PC read there is a read at 0x0100+S, then a read at 0x0100+S+1. That last byte is returned in `pull_val`, and S ends at S+1.
- R4: When P is pulled (class 3 or class 6), bits 5 and 4 of `pull_val` equal bits 5 and 4 of `p_in`. All other bits come from the stack byte.
- R5: Return (class 5) reads the PC, then 0x0100+S, 0x0100+S+1 (new PC low byte) and 0x0100+S+2 (new PC high byte). It then reads at the new PC. The final PC is that address plus one, and S ends at S+2.
- R6: Return from interrupt (class 6) reads the PC, then 0x0100+S, then P at S+1, PC low at S+2 and PC high at S+3. The PC becomes that pulled value unchanged, and S ends at S+3.
- R7: Call (class 4) reads the target low byte at PC, then reads 0x0100+S. It then writes (PC+1) high byte to 0x0100+S and (PC+1) low byte to 0x0100+S-1. Last it reads the target high byte at PC+1. The PC becomes {high, low} and S ends at S-2.
- R8: Every stack access has address bits 15:8 equal to 0x01. The stack pointer wraps modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R9: `done` is high for exactly one clock, the clock after the last bus cycle. `start` is ignored while a sequence runs, and class 7 is never accepted.
- R10: While reset is asserted and just after it, `bus_en`, `bus_wr` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_class | input | 3 | Operation class, encoding as in R2 to R7 |
| pc_in | input | 16 | PC pointing just past the opcode |
| sp_in | input | 8 | Stack pointer at start |
| a_in | input | 8 | Accumulator value to push |
| p_in | input | 8 | Status value to push; source of kept bits on pull |
| rdata | input | 8 | Read data for the current bus cycle |
| bus_en | output | 1 | A bus cycle is being issued |
| bus_addr | output | 16 | Bus address |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write data |
| done | output | 1 | One-clock completion strobe |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| pull_val | output | 8 | Byte pulled by class 2, 3 or 6 |

## Verification
A stack pointer that is off by one shows up at once as a wrong bus address on the next stack cycle. It shows again in `sp_out` when `done` rises. A wrong cycle counter changes the number of clocks before `done` and leaves a missing or extra access in the sequence, which the bench compares cycle by cycle. A bad PC latch after a pull of the low byte shows within one or two clocks, as the wrong address of the final read in a subroutine return or as a wrong `pc_out`. Pointer vectors at 0x00, 0x01, 0xFE and 0xFF expose wrap errors on the first access that crosses the boundary.

// File: rtl/sseq_pkg.sv
`timescale 1ns/1ps
package sseq_pkg;

   typedef enum logic [2:0] {
      CLS_PUSH_A = 3'd0,
      CLS_PUSH_P = 3'd1,
      CLS_PULL_A = 3'd2,
      CLS_PULL_P = 3'd3,
      CLS_CALL   = 3'd4,
      CLS_RET    = 3'd5,
      CLS_RETI   = 3'd6,
      CLS_NONE   = 3'd7
   } sseq_cls_e;

   localparam int unsigned STEP_W = 3;

   // bus cycle number (opcode fetch counts as 1) on which a class finishes
   function automatic logic [STEP_W-1:0] final_step(sseq_cls_e c);
      case (c)
         CLS_PUSH_A, CLS_PUSH_P: final_step = STEP_W'(3);
         CLS_PULL_A, CLS_PULL_P: final_step = STEP_W'(4);
         default:                final_step = STEP_W'(6);
      endcase
   endfunction

endpackage

// File: rtl/sseq_fsm.sv
`timescale 1ns/1ps
module sseq_fsm
   import sseq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          op_class,
   output logic                accept,
   output logic [STEP_W-1:0]   step,
   output sseq_cls_e           cls,
   output logic                busy,
   output logic                last
);

   logic [STEP_W-1:0] step_q;
   sseq_cls_e         cls_q;

   assign busy   = (step_q != '0);
   assign accept = !busy && start && (sseq_cls_e'(op_class) != CLS_NONE);
   assign last   = busy && (step_q == final_step(cls_q));
   assign step   = step_q;
   assign cls    = cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         cls_q  <= CLS_PUSH_A;
      end else if (accept) begin
         step_q <= STEP_W'(2);
         cls_q  <= sseq_cls_e'(op_class);
      end else if (last) begin
         step_q <= '0;
      end else if (busy) begin
         step_q <= step_q + 1'b1;
      end
   end

   // R9: a running sequence advances one step per clock regardless of start
   assert_step_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (step == $past(step) + 1'b1));

   // R9: class 7 never launches a sequence
   assert_no_launch_cls7_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op_class == 3'd7) |=> !busy);

endmodule

// File: rtl/sseq_dpath.sv
`timescale 1ns/1ps
module sseq_dpath
   import sseq_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       STACK_PAGE  = 1,
   parameter logic [DATA_W-1:0] P_KEEP_MASK = 8'h30
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [2:0]          op_class,
   input  logic [STEP_W-1:0]   step,
   input  sseq_cls_e           cls,
   input  logic [ADDR_W-1:0]   pc_in,
   input  logic [DATA_W-1:0]   sp_in,
   input  logic [DATA_W-1:0]   a_in,
   input  logic [DATA_W-1:0]   p_in,
   input  logic [DATA_W-1:0]   rdata,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bus_wr,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic [ADDR_W-1:0]   pc_q,
   output logic [DATA_W-1:0]   sp_q,
   output logic [DATA_W-1:0]   pull_q
);

   localparam logic [DATA_W-1:0] PAGE = DATA_W'(STACK_PAGE);

   logic [DATA_W-1:0] lo_q, dat_q, pkeep_q, p_merged;
   logic [ADDR_W-1:0] stk_addr;
   logic              is_push;

   assign stk_addr = {PAGE, sp_q};
   assign is_push  = (cls == CLS_PUSH_A) || (cls == CLS_PUSH_P);

   // pulled status: masked bits keep the value supplied at start
   for (genvar i = 0; i < DATA_W; i++) begin : g_pmerge
      if (P_KEEP_MASK[i]) begin : g_keep
         assign p_merged[i] = pkeep_q[i];
      end else begin : g_take
         assign p_merged[i] = rdata[i];
      end
   end

   always_comb begin
      bus_addr  = '0;
      bus_wr    = 1'b0;
      bus_wdata = '0;
      case (step)
         STEP_W'(2): bus_addr = pc_q;
         STEP_W'(3): begin
            bus_addr = stk_addr;
            if (is_push) begin
               bus_wr    = 1'b1;
               bus_wdata = dat_q;
            end
         end
         STEP_W'(4): begin
            bus_addr = stk_addr;
            if (cls == CLS_CALL) begin
               bus_wr    = 1'b1;
               bus_wdata = pc_q[ADDR_W-1:DATA_W];
            end
         end
         STEP_W'(5): begin
            bus_addr = stk_addr;
            if (cls == CLS_CALL) begin
               bus_wr    = 1'b1;
               bus_wdata = pc_q[DATA_W-1:0];
            end
         end
         STEP_W'(6): bus_addr = (cls == CLS_RETI) ? stk_addr : pc_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         sp_q    <= '0;
         lo_q    <= '0;
         dat_q   <= '0;
         pkeep_q <= '0;
         pull_q  <= '0;
      end else if (accept) begin
         pc_q    <= pc_in;
         sp_q    <= sp_in;
         pkeep_q <= p_in;
         dat_q   <= (sseq_cls_e'(op_class) == CLS_PUSH_P) ? p_in : a_in;
      end else begin
         case (step)
            STEP_W'(2): if (cls == CLS_CALL) begin
               lo_q <= rdata;
               pc_q <= pc_q + 1'b1;
            end
            STEP_W'(3): begin
               if (is_push)               sp_q <= sp_q - 1'b1;
               else if (cls != CLS_CALL)  sp_q <= sp_q + 1'b1;
            end
            STEP_W'(4): begin
               case (cls)
                  CLS_PULL_A: pull_q <= rdata;
                  CLS_PULL_P: pull_q <= p_merged;
                  CLS_RET: begin
                     pc_q[DATA_W-1:0] <= rdata;
                     sp_q <= sp_q + 1'b1;
                  end
                  CLS_RETI: begin
                     pull_q <= p_merged;
                     sp_q   <= sp_q + 1'b1;
                  end
                  CLS_CALL: sp_q <= sp_q - 1'b1;
                  default: ;
               endcase
            end
            STEP_W'(5): begin
               case (cls)
                  CLS_RET:  pc_q[ADDR_W-1:DATA_W] <= rdata;
                  CLS_RETI: begin
                     pc_q[DATA_W-1:0] <= rdata;
                     sp_q <= sp_q + 1'b1;
                  end
                  CLS_CALL: sp_q <= sp_q - 1'b1;
                  default: ;
               endcase
            end
            STEP_W'(6): begin
               case (cls)
                  CLS_RET:  pc_q <= pc_q + 1'b1;
                  CLS_RETI: pc_q[ADDR_W-1:DATA_W] <= rdata;
                  CLS_CALL: pc_q <= {rdata, lo_q};
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   // R8: writes only ever land in the stack page
   assert_write_in_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> (bus_addr[ADDR_W-1:DATA_W] == PAGE));

   // R7: the second call push goes one slot below the first, same page
   assert_call_push_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && step == STEP_W'(4)) |=>
         (bus_wr && bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0]) - 1'b1
                 && bus_addr[ADDR_W-1:DATA_W] == PAGE));

   // R5: the final return read targets the two bytes just pulled
   assert_ret_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STEP_W'(6) && cls == CLS_RET) |->
         (bus_addr == {$past(rdata), $past(rdata, 2)}));

endmodule

// File: rtl/stack_call_seq.sv
`timescale 1ns/1ps
module stack_call_seq
   import sseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STACK_PAGE  = 1,
   parameter logic [7:0]  P_KEEP_MASK = 8'h30
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_class,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic [DATA_W-1:0] rdata,
   output logic              bus_en,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] sp_out,
   output logic [DATA_W-1:0] pull_val
);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("stack_call_seq: ADDR_W must be twice DATA_W");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("stack_call_seq: status mask assumes an 8-bit data path");
   end
   if (STACK_PAGE >= (1 << DATA_W)) begin : g_bad_page
      $error("stack_call_seq: STACK_PAGE does not fit the high address byte");
   end

   logic [STEP_W-1:0] step;
   sseq_cls_e         cls;
   logic              accept, busy, last, done_q;

   sseq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op_class (op_class),
      .accept   (accept),
      .step     (step),
      .cls      (cls),
      .busy     (busy),
      .last     (last)
   );

   sseq_dpath #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STACK_PAGE  (STACK_PAGE),
      .P_KEEP_MASK (P_KEEP_MASK)
   ) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .op_class  (op_class),
      .step      (step),
      .cls       (cls),
      .pc_in     (pc_in),
      .sp_in     (sp_in),
      .a_in      (a_in),
      .p_in      (p_in),
      .rdata     (rdata),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .pc_q      (pc_out),
      .sp_q      (sp_out),
      .pull_q    (pull_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= last;
   end

   assign done   = done_q;
   assign bus_en = busy;

   // R9: completion strobe lasts one clock and follows a finished sequence
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_en);

   // R10: reset leaves the bus quiet and no strobe pending
   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |=> (!done && !bus_en && !bus_wr));

endmodule

// File: tb/stack_call_seq_test.sv
`timescale 1ns/1ps
module stack_call_seq_test;

   typedef struct packed {
      logic [2:0]  cls;
      logic [15:0] pc;
      logic [7:0]  sp;
      logic [7:0]  a;
      logic [7:0]  p;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [NVEC] = '{
      '{3'd0, 16'h1234, 8'hF0, 8'h5A, 8'hC3},
      '{3'd1, 16'h2000, 8'h80, 8'h11, 8'hE7},
      '{3'd0, 16'h0300, 8'h00, 8'hA5, 8'h00},
      '{3'd2, 16'h4100, 8'h7F, 8'h00, 8'h00},
      '{3'd3, 16'h4200, 8'h10, 8'h00, 8'h30},
      '{3'd3, 16'h4300, 8'hFF, 8'h00, 8'h00},
      '{3'd5, 16'h5000, 8'hF8, 8'h00, 8'h00},
      '{3'd5, 16'h50FF, 8'hFE, 8'h00, 8'h20},
      '{3'd6, 16'h6000, 8'hE0, 8'h00, 8'h10},
      '{3'd6, 16'h6100, 8'hFE, 8'h00, 8'h30},
      '{3'd4, 16'h80FF, 8'hFD, 8'h00, 8'h00},
      '{3'd4, 16'h9000, 8'h01, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_class = 3'd0;
   logic [15:0] pc_in = '0;
   logic [7:0]  sp_in = '0, a_in = '0, p_in = '0;
   logic [7:0]  rdata;
   logic        bus_en, bus_wr, done;
   logic [15:0] bus_addr, pc_out;
   logic [7:0]  bus_wdata, sp_out, pull_val;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   function automatic logic [7:0] fmem(input logic [15:0] ad);
      return ad[7:0] ^ 8'h96 ^ {ad[11:8], ad[15:12]};
   endfunction

   assign rdata = fmem(bus_addr);

   stack_call_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .pc_in(pc_in), .sp_in(sp_in), .a_in(a_in), .p_in(p_in), .rdata(rdata),
      .bus_en(bus_en), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .done(done), .pc_out(pc_out), .sp_out(sp_out), .pull_val(pull_val)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] stk(input logic [7:0] s);
      return {8'h01, s};
   endfunction

   function automatic logic [7:0] pmask(input logic [7:0] v, input logic [7:0] p);
      return {v[7:6], p[5:4], v[3:0]};   // R4
   endfunction

   task automatic run_op(input vec_t v, input bit poke, input string req);
      logic [15:0] ea [6];
      bit          ew [6];
      logic [7:0]  ed [6];
      int          n;
      logic [15:0] epc;
      logic [7:0]  esp, epull, s, lo, hi;
      bit          has_pull;
      s = v.sp; n = 0; has_pull = 0; epull = '0;
      for (int i = 0; i < 6; i++) begin ea[i] = '0; ew[i] = 0; ed[i] = '0; end
      ea[0] = v.pc;                        // R1
      case (v.cls)
         3'd0, 3'd1: begin               // R2
            n = 2; ea[1] = stk(s); ew[1] = 1; ed[1] = (v.cls == 3'd1) ? v.p : v.a;
            epc = v.pc; esp = s - 8'd1;
         end
         3'd2, 3'd3: begin               // R3
            n = 3; ea[1] = stk(s); ea[2] = stk(s + 8'd1);
            epull = fmem(stk(s + 8'd1));
            if (v.cls == 3'd3) epull = pmask(epull, v.p);
            has_pull = 1; epc = v.pc; esp = s + 8'd1;
         end
         3'd5: begin                     // R5
            n = 5; ea[1] = stk(s); ea[2] = stk(s + 8'd1); ea[3] = stk(s + 8'd2);
            ea[4] = {fmem(stk(s + 8'd2)), fmem(stk(s + 8'd1))};
            epc = ea[4] + 16'd1; esp = s + 8'd2;
         end
         3'd6: begin                     // R6
            n = 5; ea[1] = stk(s); ea[2] = stk(s + 8'd1);
            ea[3] = stk(s + 8'd2); ea[4] = stk(s + 8'd3);
            epull = pmask(fmem(stk(s + 8'd1)), v.p); has_pull = 1;
            epc = {fmem(stk(s + 8'd3)), fmem(stk(s + 8'd2))}; esp = s + 8'd3;
         end
         default: begin                  // R7 call
            n = 5; lo = fmem(v.pc); hi = fmem(v.pc + 16'd1);
            ea[1] = stk(s);
            ea[2] = stk(s);         ew[2] = 1; ed[2] = 8'((v.pc + 16'd1) >> 8);
            ea[3] = stk(s - 8'd1);  ew[3] = 1; ed[3] = 8'(v.pc + 16'd1);
            ea[4] = v.pc + 16'd1;
            epc = {hi, lo}; esp = s - 8'd2;
         end
      endcase

      @(negedge clk);
      op_class = v.cls; pc_in = v.pc; sp_in = v.sp; a_in = v.a; p_in = v.p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         chk(req, $sformatf("cycle %0d bus_en", i + 2), {31'd0, bus_en}, 32'd1);
         chk(req, $sformatf("cycle %0d addr", i + 2), {16'd0, bus_addr}, {16'd0, ea[i]});
         chk(req, $sformatf("cycle %0d wr", i + 2), {31'd0, bus_wr}, {31'd0, ew[i]});
         if (ew[i]) chk(req, $sformatf("cycle %0d wdata", i + 2), {24'd0, bus_wdata}, {24'd0, ed[i]});
         chk(req, "done early", {31'd0, done}, 32'd0);
         if (poke && i == 1) begin
            // R9: a start during a running sequence must change nothing
            start = 1'b1; op_class = 3'd0; pc_in = 16'hDEAD; sp_in = 8'h33;
         end
         @(negedge clk);
         start = 1'b0;
      end
      chk(req, "done strobe", {31'd0, done}, 32'd1);
      chk(req, "bus idle at done", {31'd0, bus_en}, 32'd0);
      chk(req, "pc_out", {16'd0, pc_out}, {16'd0, epc});
      chk(req, "sp_out", {24'd0, sp_out}, {24'd0, esp});
      if (has_pull) chk(req, "pull_val", {24'd0, pull_val}, {24'd0, epull});
      @(negedge clk);
      chk("R9", "done one clock", {31'd0, done}, 32'd0);
   endtask

   string tag;

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10", "bus_en in reset", {31'd0, bus_en}, 32'd0);
      chk("R10", "bus_wr in reset", {31'd0, bus_wr}, 32'd0);
      chk("R10", "done in reset", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "bus_en after reset", {31'd0, bus_en}, 32'd0);

      for (int k = 0; k < NVEC; k++) begin
         case (VEC[k].cls)
            3'd0, 3'd1: tag = (VEC[k].sp == 8'h00) ? "R2/R8 wrap" : "R2";
            3'd2:       tag = "R3";
            3'd3:       tag = (VEC[k].sp == 8'hFF) ? "R3/R4/R8 wrap" : "R3/R4";
            3'd5:       tag = "R5";
            3'd6:       tag = (VEC[k].sp == 8'hFE) ? "R6/R4/R8 wrap" : "R6/R4";
            default:    tag = (VEC[k].sp == 8'h01) ? "R7/R8 wrap" : "R7";
         endcase
         run_op(VEC[k], 1'b0, tag);
      end

      // R9: start while busy is ignored
      run_op('{3'd5, 16'h7000, 8'h40, 8'h00, 8'h00}, 1'b1, "R9 ignore start (ret)");
      run_op('{3'd4, 16'h7100, 8'h90, 8'h00, 8'h00}, 1'b1, "R9 ignore start (call)");

      // R9: class 7 is not accepted
      @(negedge clk);
      op_class = 3'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R9", "class 7 no bus", {31'd0, bus_en}, 32'd0);
         chk("R9", "class 7 no done", {31'd0, done}, 32'd0);
         @(negedge clk);
      end

      // R1: back-to-back call right after a push, first read at pc_in
      run_op('{3'd1, 16'hFFFF, 8'h00, 8'h00, 8'h5A}, 1'b0, "R1/R2");
      run_op('{3'd4, 16'hFFFF, 8'h00, 8'h00, 8'h00}, 1'b0, "R1/R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule